// File: doc/BRIEF.md
# RGB to YCbCr 4:2:2 Output Converter

This block sits at the last stage of a display pipeline, just before the pixel pins. It takes one 24-bit RGB pixel per clock, qualified by a data-enable, together with horizontal and vertical sync. When conversion is on, it turns each pixel into limited-range luma and chroma using either the BT.601 matrix or the BT.709 matrix. It then narrows the stream to a 16-bit 4:2:2 word. Each output pixel carries its own luma plus one chroma sample, and the chroma sample alternates between Cb and Cr.

The chroma of each horizontal pixel pair is the rounded mean of the two pixels. The order of Cb and Cr within a pair is programmable, and the alternation starts again on every line. When conversion is off, the RGB pixel leaves untouched on the full 24-bit bus. In both modes, sync and data-enable are delayed by the same number of cycles as the data.

Configuration comes in as one 32-bit control word. It is taken in only while vertical sync is high, so a new setting applies from the next frame onward.

Top module: `ycc422_out`

## Requirements
- R1: With conversion on, out_data[23:16] is zero during active pixels, luma is on out_data[15:8] and the chroma sample is on out_data[7:0].
- R2: The control word is decoded as follows: bit 25 turns conversion on, bit 26 selects BT.709 (1) or BT.601 (0), and bit 27 sets the chroma order. All other bits have no effect.
- R3: Each component is computed as (kR·R + kG·G + kB·B + 128) >>> 8, with an arithmetic shift. Then 16 is added for Y and 128 for Cb and Cr. The coefficients are:
  - BT.601: Y = (66, 129, 25), Cb = (−38, −74, 112), Cr = (112, −94, −18).
  - BT.709: Y = (47, 157, 16), Cb = (−26, −86, 112), Cr = (112, −102, −10).
- R4: Results are clamped to 16..235 for Y and to 16..240 for Cb and Cr.
- R5: With order 0, even pixels of a line (counting from 0) carry Cb and odd pixels carry Cr. With order 1, even pixels carry Cr and odd pixels carry Cb. The count restarts at the first active pixel after data-enable has been low.
- R6: The chroma for pixels 2k and 2k+1 is (c[2k] + c[2k+1] + 1) >> 1. A final unpaired pixel of an odd-length line carries its own first-order chroma value.
- R7: With conversion off, out_data equals the input pixel: R on [23:16], G on [15:8], B on [7:0].
- R8: The control word is captured only on cycles where in_vs is 1. After reset, the captured setting is conversion off.
- R9: out_de, out_hs, out_vs and out_data follow the inputs by exactly 4 clock cycles in both modes.
- R10: out_data is zero whenever out_de is 0. After reset, out_de is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Control word; bits 25..27 used |
| in_rgb | input | 24 | Input pixel, R in [23:16], G in [15:8], B in [7:0] |
| in_de | input | 1 | Input data-enable (active pixel) |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync; control capture window |
| out_data | output | 24 | Output pixel: RGB in bypass, {0, Y, C} when converting |
| out_de | output | 1 | Delayed data-enable |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |

## Verification
Two situations are the hardest to reach from the ports. The first is the trailing unpaired pixel of an odd-length line. The second is a change of the control word outside the vertical sync window. The stimulus drives lines of odd length, including a single-pixel line, so that the look-ahead partner is absent. It also rewrites the control word with conflicting values right after each vertical sync, and the scoreboard still expects the captured setting. Lines of saturated primaries drive luma and chroma to their range limits in both matrices.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

  localparam int COEF_FRAC = 8;
  localparam int COEF_W    = 10;

  // Positions of the fields inside the control word
  localparam int CFG_EN_BIT  = 25;
  localparam int CFG_STD_BIT = 26;
  localparam int CFG_ORD_BIT = 27;

  typedef struct packed {
    logic order;   // 1: Cr first in each pair
    logic std709;  // 1: BT.709 matrix, 0: BT.601
    logic en;      // 1: convert to 4:2:2
  } out_cfg_t;

  typedef enum logic {PH_FIRST = 1'b0, PH_SECOND = 1'b1} pair_ph_e;

  // Matrix coefficient, scaled by 2^COEF_FRAC; row 0:Y 1:Cb 2:Cr, col 0:R 1:G 2:B
  function automatic logic signed [COEF_W-1:0] coef(input logic std709,
                                                    input int row, input int col);
    int v;
    v = 0;
    if (std709) begin
      case (row*3 + col)
        0: v = 47;   1: v = 157;  2: v = 16;
        3: v = -26;  4: v = -86;  5: v = 112;
        6: v = 112;  7: v = -102; 8: v = -10;
        default: v = 0;
      endcase
    end else begin
      case (row*3 + col)
        0: v = 66;   1: v = 129;  2: v = 25;
        3: v = -38;  4: v = -74;  5: v = 112;
        6: v = 112;  7: v = -94;  8: v = -18;
        default: v = 0;
      endcase
    end
    return COEF_W'(v);
  endfunction

endpackage

// File: rtl/ycc_matrix.sv
module ycc_matrix
  import ycc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          std709,
  input  logic [3*CW-1:0] in_rgb,
  input  logic          in_de,
  output logic [3*CW-1:0] out_rgb,
  output logic [CW-1:0] out_y,
  output logic [CW-1:0] out_cb,
  output logic [CW-1:0] out_cr,
  output logic          out_de
);

  localparam int AW     = CW + COEF_W + 3;
  localparam int OFS_SH = CW - 8;
  localparam int RND    = 1 << (COEF_FRAC - 1);
  localparam int LO_LIM = 16 << OFS_SH;

  for (genvar row = 0; row < 3; row++) begin : g_row
    localparam int OFS = (row == 0) ? (16 << OFS_SH) : (128 << OFS_SH);
    localparam int HI  = (row == 0) ? (235 << OFS_SH) : (240 << OFS_SH);

    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] scaled;
    logic [CW-1:0]        res;

    always_comb begin
      acc = AW'(RND);
      for (int col = 0; col < 3; col++) begin
        acc = acc + AW'(coef(std709, row, col)) *
                    $signed({{(AW-CW){1'b0}}, in_rgb[(2-col)*CW +: CW]});
      end
      scaled = (acc >>> COEF_FRAC) + AW'(OFS);
      if (scaled < AW'(LO_LIM))      res = CW'(LO_LIM);
      else if (scaled > AW'(HI))     res = CW'(HI);
      else                           res = scaled[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_de  <= 1'b0;
      out_rgb <= '0;
      out_y   <= '0;
      out_cb  <= '0;
      out_cr  <= '0;
    end else begin
      out_de  <= in_de;
      out_rgb <= in_rgb;
      out_y   <= g_row[0].res;
      out_cb  <= g_row[1].res;
      out_cr  <= g_row[2].res;
    end
  end

endmodule

// File: rtl/ycc_pair_pack.sv
module ycc_pair_pack
  import ycc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            order,
  input  logic [3*CW-1:0] in_rgb,
  input  logic [CW-1:0]   in_y,
  input  logic [CW-1:0]   in_cb,
  input  logic [CW-1:0]   in_cr,
  input  logic            in_de,
  output logic [3*CW-1:0] out_data,
  output logic            out_de
);

  // Current pixel (cur_*) while in_* is the look-ahead partner
  logic [3*CW-1:0] cur_rgb;
  logic [CW-1:0]   cur_y, cur_cb, cur_cr;
  logic            cur_de;
  logic [CW-1:0]   held_c;
  pair_ph_e        phase;

  logic [CW:0]     sum_cb, sum_cr;
  logic [CW-1:0]   pair_cb, pair_cr, first_c, second_c;

  always_comb begin
    sum_cb  = {1'b0, cur_cb} + {1'b0, in_cb} + (CW+1)'(1);
    sum_cr  = {1'b0, cur_cr} + {1'b0, in_cr} + (CW+1)'(1);
    pair_cb = in_de ? sum_cb[CW:1] : cur_cb;
    pair_cr = in_de ? sum_cr[CW:1] : cur_cr;
    first_c  = order ? pair_cr : pair_cb;
    second_c = order ? pair_cb : pair_cr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_rgb <= '0;
      cur_y   <= '0;
      cur_cb  <= '0;
      cur_cr  <= '0;
      cur_de  <= 1'b0;
    end else begin
      cur_rgb <= in_rgb;
      cur_y   <= in_y;
      cur_cb  <= in_cb;
      cur_cr  <= in_cr;
      cur_de  <= in_de;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_FIRST;
      held_c   <= '0;
      out_data <= '0;
      out_de   <= 1'b0;
    end else begin
      out_de <= cur_de;
      if (!cur_de) begin
        phase    <= PH_FIRST;
        out_data <= '0;
      end else begin
        phase <= (phase == PH_FIRST) ? PH_SECOND : PH_FIRST;
        if (!en) begin
          out_data <= cur_rgb;
        end else if (phase == PH_FIRST) begin
          out_data <= {{CW{1'b0}}, cur_y, first_c};
          held_c   <= second_c;
        end else begin
          out_data <= {{CW{1'b0}}, cur_y, held_c};
        end
      end
    end
  end

endmodule

// File: rtl/sync_delay.sv
module sync_delay #(
  parameter int W     = 2,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [DEPTH-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];

endmodule

// File: rtl/ycc422_out.sv
module ycc422_out
  import ycc_pkg::*;
#(
  parameter int CW    = 8,
  parameter int CFG_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [3*CW-1:0] in_rgb,
  input  logic            in_de,
  input  logic            in_hs,
  input  logic            in_vs,
  output logic [3*CW-1:0] out_data,
  output logic            out_de,
  output logic            out_hs,
  output logic            out_vs
);

  // Input reg + matrix reg + pair reg + output reg
  localparam int LAT = 4;

  out_cfg_t        cfg_q;
  logic [3*CW-1:0] s1_rgb;
  logic            s1_de;
  logic [3*CW-1:0] s2_rgb;
  logic [CW-1:0]   s2_y, s2_cb, s2_cr;
  logic            s2_de;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (in_vs) begin
      cfg_q.en     <= cfg_word[CFG_EN_BIT];
      cfg_q.std709 <= cfg_word[CFG_STD_BIT];
      cfg_q.order  <= cfg_word[CFG_ORD_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_rgb <= '0;
      s1_de  <= 1'b0;
    end else begin
      s1_rgb <= in_rgb;
      s1_de  <= in_de;
    end
  end

  ycc_matrix #(.CW(CW)) u_matrix (
    .clk    (clk),
    .rst    (rst),
    .std709 (cfg_q.std709),
    .in_rgb (s1_rgb),
    .in_de  (s1_de),
    .out_rgb(s2_rgb),
    .out_y  (s2_y),
    .out_cb (s2_cb),
    .out_cr (s2_cr),
    .out_de (s2_de)
  );

  ycc_pair_pack #(.CW(CW)) u_pack (
    .clk     (clk),
    .rst     (rst),
    .en      (cfg_q.en),
    .order   (cfg_q.order),
    .in_rgb  (s2_rgb),
    .in_y    (s2_y),
    .in_cb   (s2_cb),
    .in_cr   (s2_cr),
    .in_de   (s2_de),
    .out_data(out_data),
    .out_de  (out_de)
  );

  sync_delay #(.W(2), .DEPTH(LAT)) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({in_hs, in_vs}),
    .q  ({out_hs, out_vs})
  );

endmodule

// File: rtl/ycc422_out_chk.sv
module ycc422_out_chk
  import ycc_pkg::*;
#(
  parameter int CW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            in_de,
  input logic            in_hs,
  input logic            in_vs,
  input logic [3*CW-1:0] out_data,
  input logic            out_de,
  input logic            out_hs,
  input logic            out_vs,
  input out_cfg_t        cfg_q
);

  localparam int OFS_SH = CW - 8;
  localparam logic [CW-1:0] LO_L = CW'(16 << OFS_SH);
  localparam logic [CW-1:0] Y_HI = CW'(235 << OFS_SH);
  localparam logic [CW-1:0] C_HI = CW'(240 << OFS_SH);

  logic [2:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  // The 4 below is the fixed pipeline depth of the top module
  AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4) |->
      (out_de == $past(in_de, 4) && out_hs == $past(in_hs, 4) &&
       out_vs == $past(in_vs, 4))); // R9

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (rst)
    !out_de |-> (out_data == '0)); // R10

  AST_NARROW_BUS: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.en && out_de) |-> (out_data[3*CW-1:2*CW] == '0)); // R1

  AST_LUMA_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.en && out_de) |->
      (out_data[2*CW-1:CW] >= LO_L && out_data[2*CW-1:CW] <= Y_HI)); // R4

  AST_CHROMA_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.en && out_de) |->
      (out_data[CW-1:0] >= LO_L && out_data[CW-1:0] <= C_HI)); // R4

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd2 && !$past(in_vs)) |-> $stable(cfg_q)); // R8

endmodule

bind ycc422_out ycc422_out_chk #(.CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_de   (in_de),
  .in_hs   (in_hs),
  .in_vs   (in_vs),
  .out_data(out_data),
  .out_de  (out_de),
  .out_hs  (out_hs),
  .out_vs  (out_vs),
  .cfg_q   (cfg_q)
);

// File: tb/sim_ycc422_out.sv
module sim_ycc422_out;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_word = '0;
  logic [23:0] in_rgb = '0;
  logic        in_de = 1'b0;
  logic        in_hs = 1'b0;
  logic        in_vs = 1'b0;
  logic [23:0] out_data;
  logic        out_de, out_hs, out_vs;

  int checks = 0;
  int fails  = 0;

  logic [23:0] exp_q[$];
  string       tag_q[$];

  logic [2:0]  hist [0:4];
  int          hist_n = 0;

  always #10 clk = ~clk;

  ycc422_out u0 (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .in_rgb(in_rgb),
    .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
    .out_data(out_data), .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%06h expected=%06h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Spec formula (R3, R4)
  function automatic int comp(input bit s709, input int row,
                              input int r, input int g, input int b);
    int k[3];
    int v;
    int lim;
    if (s709) begin
      case (row)
        0: k = '{47, 157, 16};
        1: k = '{-26, -86, 112};
        default: k = '{112, -102, -10};
      endcase
    end else begin
      case (row)
        0: k = '{66, 129, 25};
        1: k = '{-38, -74, 112};
        default: k = '{112, -94, -18};
      endcase
    end
    v = ((k[0]*r + k[1]*g + k[2]*b + 128) >>> 8) + ((row == 0) ? 16 : 128);
    lim = (row == 0) ? 235 : 240;
    if (v < 16) v = 16;
    if (v > lim) v = lim;
    return v;
  endfunction

  function automatic logic [23:0] pix(input int kind, input int i, input int ln);
    if (kind == 1) begin
      case (i % 8)
        0: return 24'hFFFFFF;
        1: return 24'h000000;
        2: return 24'hFF0000;
        3: return 24'h00FF00;
        4: return 24'h0000FF;
        5: return 24'hFFFF00;
        6: return 24'h00FFFF;
        default: return 24'hFF00FF;
      endcase
    end
    return {8'(i*37 + ln*11 + 5), 8'(i*91 + ln*5 + 60), 8'(i*13 + ln*71 + 200)};
  endfunction

  task automatic send_line(input int n, input int kind, input int ln,
                           input bit en, input bit s709, input bit ord);
    logic [23:0] px [32];
    int y [32];
    int cb[32];
    int cr[32];
    int fst, snd, pcb, pcr;
    for (int i = 0; i < n; i++) begin
      px[i] = pix(kind, i, ln);
      y[i]  = comp(s709, 0, int'(px[i][23:16]), int'(px[i][15:8]), int'(px[i][7:0]));
      cb[i] = comp(s709, 1, int'(px[i][23:16]), int'(px[i][15:8]), int'(px[i][7:0]));
      cr[i] = comp(s709, 2, int'(px[i][23:16]), int'(px[i][15:8]), int'(px[i][7:0]));
    end
    snd = 0;
    for (int i = 0; i < n; i++) begin
      if (!en) begin
        exp_q.push_back(px[i]);
        tag_q.push_back("R7 bypass");
      end else if (i % 2 == 0) begin
        if (i + 1 < n) begin
          pcb = (cb[i] + cb[i+1] + 1) >> 1;
          pcr = (cr[i] + cr[i+1] + 1) >> 1;
          tag_q.push_back("R3/R5/R6 pair first");
        end else begin
          pcb = cb[i];
          pcr = cr[i];
          tag_q.push_back("R6 unpaired tail");
        end
        fst = ord ? pcr : pcb;
        snd = ord ? pcb : pcr;
        exp_q.push_back({8'h00, 8'(y[i]), 8'(fst)});
      end else begin
        exp_q.push_back({8'h00, 8'(y[i]), 8'(snd)});
        tag_q.push_back("R3/R5/R6 pair second");
      end
    end
    in_hs = 1'b1; tick(); tick();
    in_hs = 1'b0; tick(); tick();
    for (int i = 0; i < n; i++) begin
      in_de = 1'b1; in_rgb = px[i]; tick();
    end
    in_de = 1'b0; in_rgb = '0;
    tick(); tick(); tick();
  endtask

  task automatic frame_start(input logic [31:0] cfg_vs, input logic [31:0] cfg_act);
    cfg_word = cfg_vs;
    in_vs = 1'b1; tick(); tick(); tick();
    in_vs = 1'b0; tick();
    cfg_word = cfg_act;   // R8: must be ignored until the next vsync
    tick();
  endtask

  // Monitor: scoreboard and latency
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = {in_hs, in_vs, in_de};
      if (hist_n < 5) hist_n++;
      if (hist_n >= 5) begin
        check({out_hs, out_vs, out_de} == hist[4], "R9 sync latency",
              24'({out_hs, out_vs, out_de}), 24'(hist[4]));
      end
      if (out_de) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected pixel", out_data, 24'h0);
        end else begin
          logic [23:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e, t, out_data, e);
        end
      end else begin
        check(out_data == 24'h0, "R10 blank zero", out_data, 24'h0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) hist[i] = '0;
    rst = 1'b1;
    tick(); tick(); tick();
    @(negedge clk);
    check(out_de == 1'b0 && out_data == 24'h0, "R10 reset state",
          {out_data[22:0], out_de}, 24'h0);
    @(posedge clk); #1;
    rst = 1'b0;
    tick();

    // R8: no vsync since reset, so enable bits set here are not captured
    cfg_word = 32'h0E00_0000;
    send_line(4, 0, 0, 1'b0, 1'b0, 1'b0);

    // R2/R7: bypass with unrelated bits set; conflicting word after vsync
    frame_start(32'hF1FF_FFFF, 32'h0E00_0000);
    send_line(6, 0, 1, 1'b0, 1'b0, 1'b0);
    send_line(5, 0, 2, 1'b0, 1'b0, 1'b0);

    // R3/R5/R6: BT.601, Cb first, odd widths and a single pixel line
    frame_start(32'h0200_00FF, 32'h0000_0000);
    send_line(8, 0, 3, 1'b1, 1'b0, 1'b0);
    send_line(7, 0, 4, 1'b1, 1'b0, 1'b0);
    send_line(1, 0, 5, 1'b1, 1'b0, 1'b0);

    // R3/R5: BT.709, Cr first
    frame_start(32'h0E00_0000, 32'h0200_0000);
    send_line(6, 0, 6, 1'b1, 1'b1, 1'b1);
    send_line(3, 0, 7, 1'b1, 1'b1, 1'b1);

    // R4: saturated primaries in both matrices
    frame_start(32'h0A00_0000, 32'h0400_0000);
    send_line(8, 1, 8, 1'b1, 1'b0, 1'b1);
    frame_start(32'h0600_0000, 32'h0800_0000);
    send_line(8, 1, 9, 1'b1, 1'b1, 1'b0);
    send_line(9, 0, 10, 1'b1, 1'b1, 1'b0);

    // Back to bypass
    frame_start(32'h0000_0000, 32'h0E00_0000);
    send_line(5, 0, 11, 1'b0, 1'b0, 1'b0);

    repeat (10) tick();
    check(exp_q.size() == 0, "R9 all pixels emitted", 24'(exp_q.size()), 24'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule